// File: doc/BRIEF.md
# Two-Wire Clock-Enable Register Slave

This block is the control side of an 18-output clock fanout. A bus master on a two-wire serial bus (SCL and SDA, both open-drain) writes three 8-bit enable registers. Each enable bit gates one copy of a reference clock onto its own output pin. One active-low output enable input stops all outputs from being driven, whatever the registers hold, so a board tester can take over the nets.

The slave answers two 7-bit device addresses, and the address it matches sets the command format. The plain I2C address (a parameter) starts data transfers at register byte 0 right after the address byte. The SMBus address takes a block format. A block write carries a command byte, then a byte count, then the data. A block read returns the byte count first and then the data. The register pointer wraps from the last byte back to byte 0, for reads and for writes. Both bus lines are synchronised into a system clock that runs at least eight times faster than SCL, and every bus event is decoded in that clock.

Top module: `clkgate_twowire_slave`

## Requirements
- R1: After reset all 24 control bits read as one. Every clock output follows `ref_clk_i`, and a plain I2C read returns 8'hFF for byte 0, byte 1 and byte 2.
- R2: A START (SDA falls while SCL is high) begins a new address phase from any state, and a byte cut short by a repeated START writes nothing. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: The slave answers only the I2C address (parameter, default 7'b1101000) and the SMBus address 7'b1101001, where bit 0 of the address byte is 1 for a read. For any other address it drives no acknowledge, and the data bytes that follow change no register.
- R4: When addressed, the slave pulls SDA low through the ninth SCL pulse after each byte it receives, including the address byte.
- R5: In I2C write mode, the data bytes after the address byte go to byte 0, byte 1 and byte 2 in that order, each received MSB first.
- R6: A write that runs past byte 2 continues at byte 0. The fourth data byte overwrites byte 0 and the fifth overwrites byte 1.
- R7: An I2C read sends byte 0, byte 1, byte 2 and then byte 0 again, MSB first. The slave places each bit on SDA while SCL is low.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released on any further SCL pulses until the next START or STOP.
- R9: In SMBus write mode the first byte is a command code and is ignored, and the second byte is a byte count N. The next N data bytes are written from byte 0. Data bytes beyond N are acknowledged and discarded.
- R10: An SMBus read first returns the register byte count, 8'd3, and then byte 0, byte 1 and byte 2 in order.
- R11: Clock output n is `ref_clk_i` when bit n of {byte 2, byte 1, byte 0} is one, and it stays low when that bit is zero (n = 0 to 17). Bits 18 to 23 are stored and read back, but they gate nothing.
- R12: While `oe_n_i` is low, every clock output is low and `out_drive_o` is low, which means the pins float. The registers keep their contents, and the outputs return to their enabled pattern when `oe_n_i` goes high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| oe_n_i | input | 1 | Active-low output enable for all clock outputs |
| clk_out_o | output | 18 | Gated copies of the reference clock |
| out_drive_o | output | 1 | 1 when the clock output pins are driven, 0 when they float |

## Verification
A wrong bit counter or bus state shows up within one byte time on SDA. The acknowledge comes in the wrong SCL pulse or not at all, or the read data is shifted by one bit. A pointer or wrap error stays hidden until a transfer runs past byte 2. It then shows up as the wrong register read back or written, so the bench always runs transfers of four or more bytes. A register corrupted by a foreign address, by a partial byte or by discarded SMBus bytes is seen at once on the gated clock outputs, and is confirmed by a later read.

// File: rtl/twc_pkg.sv
package twc_pkg;

    // Defaults shared by the blocks of the slave
    localparam int          REG_BYTES_DEF = 3;
    localparam int          OUT_COUNT_DEF = 18;
    localparam logic [6:0]  SMB_ADDR_DEF  = 7'b1101001;
    localparam logic [6:0]  I2C_ADDR_DEF  = 7'b1101000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } link_state_e;

    typedef enum logic {
        MODE_I2C,
        MODE_SMB
    } link_mode_e;

    typedef enum logic [1:0] {
        SMB_CMD,
        SMB_CNT,
        SMB_DATA
    } smb_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_evt_t;

    // Bus events from the current and previous synchronised samples
    function automatic line_evt_t decode_evt(input logic scl_now, input logic scl_old,
                                             input logic sda_now, input logic sda_old);
        line_evt_t e;
        e.start = scl_now & scl_old & sda_old & ~sda_now;
        e.stop  = scl_now & scl_old & ~sda_old & sda_now;
        e.rise  = scl_now & ~scl_old;
        e.fall  = ~scl_now & scl_old;
        e.sda   = sda_now;
        return e;
    endfunction

endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync
    import twc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign evt = decode_evt(scl_ff[STAGES-1], scl_d, sda_ff[STAGES-1], sda_d);

endmodule

// File: rtl/twc_regbank.sv
module twc_regbank #(
    parameter int NUM_BYTES = 3,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int BITS     = NUM_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [BITS-1:0]  bank
);

    logic [BITS-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '1;
        end else if (wr_en) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (wr_idx == IDX_W'(b)) begin
                    bank_q[b*8 +: 8] <= wr_data;
                end
            end
        end
    end

    assign rd_data = bank_q[int'(rd_idx)*8 +: 8];
    assign bank    = bank_q;

    // R1
    rst_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_q == '1));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_BYTES));

endmodule

// File: rtl/twc_link_fsm.sv
module twc_link_fsm
    import twc_pkg::*;
#(
    parameter int         NUM_BYTES = 3,
    parameter logic [6:0] I2C_ADDR  = I2C_ADDR_DEF,
    parameter logic [6:0] SMB_ADDR  = SMB_ADDR_DEF,
    localparam int        IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  line_evt_t        evt,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull
);

    localparam logic [7:0] CNT_BYTE = 8'(NUM_BYTES);

    link_state_e      st;
    link_mode_e       mode;
    smb_phase_e       smb_ph;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       smb_left;
    logic [IDX_W-1:0] idx;
    logic             go_rd;
    logic             cnt_first;
    logic             nack_q;
    logic [7:0]       tx_byte;
    logic             hit_i2c;
    logic             hit_smb;

    function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(NUM_BYTES - 1)) ? '0 : v + 1'b1;
    endfunction

    assign tx_byte = (mode == MODE_SMB && cnt_first) ? CNT_BYTE : rd_data;
    assign hit_i2c = (shreg[7:1] == I2C_ADDR);
    assign hit_smb = (shreg[7:1] == SMB_ADDR);
    assign rd_idx  = idx;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            st        <= ST_IDLE;
            mode      <= MODE_I2C;
            smb_ph    <= SMB_CMD;
            bitcnt    <= '0;
            shreg     <= '0;
            smb_left  <= '0;
            idx       <= '0;
            go_rd     <= 1'b0;
            cnt_first <= 1'b0;
            nack_q    <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            sda_pull  <= 1'b0;
        end else if (evt.stop) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WDATA: begin
                    if (evt.rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (st == ST_ADDR) begin
                            if (hit_i2c || hit_smb) begin
                                mode      <= hit_smb ? MODE_SMB : MODE_I2C;
                                go_rd     <= shreg[0];
                                cnt_first <= hit_smb & shreg[0];
                                smb_ph    <= SMB_CMD;
                                idx       <= '0;
                                sda_pull  <= 1'b1;
                                st        <= ST_ACK;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end else begin
                            go_rd    <= 1'b0;
                            sda_pull <= 1'b1;
                            st       <= ST_ACK;
                            if (mode == MODE_I2C) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= idx;
                                wr_data <= shreg;
                                idx     <= idx_step(idx);
                            end else begin
                                unique case (smb_ph)
                                    SMB_CMD: smb_ph <= SMB_CNT;
                                    SMB_CNT: begin
                                        smb_left <= shreg;
                                        smb_ph   <= SMB_DATA;
                                    end
                                    default: begin
                                        if (smb_left != 8'd0) begin
                                            wr_en    <= 1'b1;
                                            wr_idx   <= idx;
                                            wr_data  <= shreg;
                                            idx      <= idx_step(idx);
                                            smb_left <= smb_left - 8'd1;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.fall) begin
                        bitcnt <= '0;
                        if (go_rd) begin
                            shreg    <= tx_byte;
                            sda_pull <= ~tx_byte[7];
                            if (cnt_first) cnt_first <= 1'b0;
                            else           idx       <= idx_step(idx);
                            st       <= ST_RDATA;
                        end else begin
                            sda_pull <= 1'b0;
                            st       <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (evt.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            st       <= ST_MACK;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_pull <= ~shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (evt.rise) begin
                        nack_q <= evt.sda;
                    end else if (evt.fall) begin
                        bitcnt <= '0;
                        if (!nack_q) begin
                            shreg    <= tx_byte;
                            sda_pull <= ~tx_byte[7];
                            if (cnt_first) cnt_first <= 1'b0;
                            else           idx       <= idx_step(idx);
                            st       <= ST_RDATA;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !evt.stop) |=> (st == ST_ADDR && bitcnt == 4'd0));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (st == ST_IDLE && !sda_pull));

    // R3
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !sda_pull);

    // R9
    smb_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_SMB) |-> ($past(smb_left) != 8'd0));

endmodule

// File: rtl/twc_clk_gate.sv
module twc_clk_gate #(
    parameter int NUM_OUTS = 18
) (
    input  logic                ref_clk,
    input  logic                oe_n,
    input  logic [NUM_OUTS-1:0] en,
    output logic [NUM_OUTS-1:0] clk_out,
    output logic                drive
);

    for (genvar g = 0; g < NUM_OUTS; g++) begin : g_lane
        assign clk_out[g] = ref_clk & en[g] & oe_n;
    end

    assign drive = oe_n;

endmodule

// File: rtl/clkgate_twowire_slave.sv
module clkgate_twowire_slave
    import twc_pkg::*;
#(
    parameter int         NUM_BYTES   = REG_BYTES_DEF,
    parameter int         NUM_OUTS    = OUT_COUNT_DEF,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] I2C_ADDR    = I2C_ADDR_DEF,
    parameter logic [6:0] SMB_ADDR    = SMB_ADDR_DEF,
    localparam int        IDX_W       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int        BITS        = NUM_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    input  logic                ref_clk_i,
    input  logic                oe_n_i,
    output logic [NUM_OUTS-1:0] clk_out_o,
    output logic                out_drive_o
);

    line_evt_t        evt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic [BITS-1:0]  bank;

    twc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    twc_link_fsm #(
        .NUM_BYTES (NUM_BYTES),
        .I2C_ADDR  (I2C_ADDR),
        .SMB_ADDR  (SMB_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_pull (sda_pull_o)
    );

    twc_regbank #(.NUM_BYTES(NUM_BYTES)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .bank    (bank)
    );

    twc_clk_gate #(.NUM_OUTS(NUM_OUTS)) u_gate (
        .ref_clk (ref_clk_i),
        .oe_n    (oe_n_i),
        .en      (bank[NUM_OUTS-1:0]),
        .clk_out (clk_out_o),
        .drive   (out_drive_o)
    );

    // R12
    oe_float_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n_i |-> (clk_out_o == '0 && !out_drive_o));

endmodule

// File: tb/test_clkgate_twowire_slave.sv
module test_clkgate_twowire_slave;

    localparam int H  = 16;
    localparam int Q  = 8;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        ref_clk = 1'b0;
    logic        oe_n = 1'b1;
    logic        sda_pull;
    logic [17:0] clk_out;
    logic        out_drive;
    wire         sda_line = sda_m & ~sda_pull;

    int nchk  = 0;
    int nfail = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];
    logic [7:0] txq[$];

    always #10 clk = ~clk;

    clkgate_twowire_slave i_clkgate_twowire_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .ref_clk_i   (ref_clk),
        .oe_n_i      (oe_n),
        .clk_out_o   (clk_out),
        .out_drive_o (out_drive)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: pairs each captured read byte with its expectation
    logic [7:0] mon_g, mon_e;
    string      mon_t;
    always @(posedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            mon_g = got_q.pop_front();
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(mon_t, 32'(mon_g), 32'(mon_e));
        end
    end

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        wait_n(Q); sda_m = b;
        wait_n(Q); scl_m = 1'b1;
        wait_n(H); seen = sda_line;
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(Q); sda_m = 1'b1;
        wait_n(Q); scl_m = 1'b1;
        wait_n(H); sda_m = 1'b0;
        wait_n(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(Q); sda_m = 1'b0;
        wait_n(Q); scl_m = 1'b1;
        wait_n(H); sda_m = 1'b1;
        wait_n(H);
    endtask

    task automatic wr_byte(input logic [7:0] tx, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(tx[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] rx);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            rx[i] = s;
        end
        bus_bit(~mack, s);
    endtask

    // Address byte then the bytes in txq; every ack compared with exp_ack
    task automatic send_frame(input logic [7:0] addr, input logic exp_ack, input string tag);
        logic a;
        bus_start();
        wr_byte(addr, a);
        chk(tag, 32'(a), 32'(exp_ack));
        for (int k = 0; k < txq.size(); k++) begin
            wr_byte(txq[k], a);
            chk(tag, 32'(a), 32'(exp_ack));
        end
        bus_stop();
        txq.delete();
    endtask

    // Read n bytes, NACK the last, then probe one more SCL pulse for release (R8)
    task automatic read_frame(input logic [7:0] addr, input int n);
        logic       a;
        logic [7:0] rx;
        bus_start();
        wr_byte(addr, a);
        chk("R4 read address ack", 32'(a), 32'd1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k < n - 1, rx);
            got_q.push_back(rx);
        end
        bus_bit(1'b1, a);
        chk("R8 SDA released after NACK", 32'(a), 32'd1);
        bus_stop();
    endtask

    task automatic chk_outs(input logic [17:0] exp, input string tag);
        ref_clk = 1'b1;
        wait_n(2);
        chk(tag, 32'(clk_out), 32'(exp));
        chk(tag, 32'(out_drive), 32'd1);
        ref_clk = 1'b0;
        wait_n(2);
        chk(tag, 32'(clk_out), 32'd0);
    endtask

    initial begin
        logic a;
        logic [7:0] rx;
        wait_n(5);
        rst = 1'b0;
        wait_n(5);

        // R1: reset pattern
        chk_outs(18'h3FFFF, "R1 reset outputs");
        expect_byte("R1 reset byte0", 8'hFF);
        expect_byte("R1 reset byte1", 8'hFF);
        expect_byte("R1 reset byte2", 8'hFF);
        read_frame(8'hD1, 3);

        // R5, R4, R11: I2C write, outputs = {b2[1:0], b1, b0}
        txq = '{8'h5A, 8'hC3, 8'h02};
        send_frame(8'hD0, 1'b1, "R4 I2C write ack");
        chk_outs(18'h2C35A, "R5 R11 outputs after write");

        // R7: read with wrap to byte 0
        expect_byte("R7 read byte0", 8'h5A);
        expect_byte("R7 read byte1", 8'hC3);
        expect_byte("R7 read byte2", 8'h02);
        expect_byte("R7 read wrap byte0", 8'h5A);
        read_frame(8'hD1, 4);

        // R6: five data bytes, last two overwrite byte0 and byte1
        txq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        send_frame(8'hD0, 1'b1, "R4 wrap write ack");
        expect_byte("R6 wrapped byte0", 8'h44);
        expect_byte("R6 wrapped byte1", 8'h55);
        expect_byte("R6 kept byte2", 8'h33);
        read_frame(8'hD1, 3);

        // R3: foreign address is not acked and changes nothing
        txq = '{8'h00};
        send_frame(8'hA0, 1'b0, "R3 foreign address no ack");
        chk_outs(18'h35544, "R3 outputs unchanged");

        // R9: SMBus block write, count 2, third data byte discarded but acked
        txq = '{8'h00, 8'h02, 8'h0F, 8'hF0, 8'hAA};
        send_frame(8'hD2, 1'b1, "R9 SMBus write ack");
        chk_outs(18'h3F00F, "R9 outputs after block write");

        // R10: SMBus block read returns count then data
        expect_byte("R10 count byte", 8'h03);
        expect_byte("R10 byte0", 8'h0F);
        expect_byte("R10 byte1", 8'hF0);
        expect_byte("R10 byte2", 8'h33);
        read_frame(8'hD3, 4);

        // R12: output enable low floats and silences all outputs
        oe_n = 1'b0;
        ref_clk = 1'b1;
        wait_n(2);
        chk("R12 outputs low with OE low", 32'(clk_out), 32'd0);
        chk("R12 drive off with OE low", 32'(out_drive), 32'd0);
        ref_clk = 1'b0;
        oe_n = 1'b1;
        wait_n(2);
        chk_outs(18'h3F00F, "R12 outputs restored");

        // R2: partial byte cut by repeated START writes nothing
        bus_start();
        wr_byte(8'hD0, a);
        chk("R2 address ack", 32'(a), 32'd1);
        bus_bit(1'b1, a);
        bus_bit(1'b0, a);
        bus_bit(1'b1, a);
        bus_bit(1'b0, a);
        bus_start();
        wr_byte(8'hD1, a);
        chk("R2 repeated start ack", 32'(a), 32'd1);
        expect_byte("R2 byte0 untouched", 8'h0F);
        rd_byte(1'b0, rx);
        got_q.push_back(rx);
        bus_stop();

        // R11: all enables cleared holds every output low
        txq = '{8'h00, 8'h00, 8'h00};
        send_frame(8'hD0, 1'b1, "R4 clear write ack");
        chk_outs(18'h00000, "R11 all outputs held low");

        while (got_q.size() != 0) wait_n(1);
        wait_n(4);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule